// File: doc/BRIEF.md
# Load Stream and Stride Prefetch Tracker

This block watches the addresses and instruction addresses of executed loads and turns recognisable patterns into cache-line prefetch requests. Two line-granular stream tables follow runs of loads through memory: a larger one for upward runs and a smaller one for downward runs. A load that matches no entry in either table opens a new entry in both, replacing the least recently touched entry of each. The next load that steps one line onward from an entry, which is the second load of that stream, requests the line one step beyond it.

A third table is indexed by the low bits of the load's instruction address. It learns the byte distance between successive loads issued by the same instruction. After that distance has repeated, it requests the line one distance ahead, in either direction. Requests never leave the aligned 2 KB window that holds the triggering load. A request that is already waiting in the output queue is dropped.

Requests wait in a small queue and leave it on a valid/ready handshake. At most one request is formed per load. A stream step takes precedence over a stride prediction for the same load.

Top module: `prefetch_tracker`

## Requirements
- R1: After reset `pf_valid` is low and stays low until a load pattern below produces a request.
- R2: A load to the same 64-byte line as an entry's last line (line = byte address bits [31:6]) only refreshes that entry: no request is made, and the entry still follows its stream afterwards.
- R3: A load to line L that misses both tables, followed by a load to line L+1, requests line L+2 on `pf_line`. Each further one-line upward step of the stream requests the next line up.
- R4: A load to line L that misses both tables, followed by a load to line L-1, requests line L-2. Each further downward step requests the next line down.
- R5: The upward table holds 16 entries with least-recently-used replacement, where a refresh counts as a use. A stream survives 15 newer allocations and is lost after 16.
- R6: The downward table holds 4 entries with least-recently-used replacement. A stream survives 3 newer allocations and is lost after 4.
- R7: The stride table is direct-mapped on `ld_pc` bits [2:0] and tagged by the remaining bits. It keeps a 2-bit confidence that a repeated non-zero byte delta raises and any other delta clears. A load whose delta has now repeated twice in a row (the fourth evenly spaced load) requests the line of address + delta, whether the delta is positive or negative.
- R8: No request is made whose line lies in a different aligned 2 KB window (line bits [25:5]) from the triggering load's line.
- R9: Requests leave in the order they were made. While `pf_valid` is high and `pf_ready` is low, `pf_valid` stays high and `pf_line` holds its value.
- R10: A request for a line that is already waiting in the queue is dropped.
- R11: The queue holds 4 requests. A request made while it is full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | A load is observed this cycle |
| ld_addr | input | 32 | Byte address of the load |
| ld_pc | input | 32 | Instruction address of the load |
| pf_valid | output | 1 | A prefetch request is offered |
| pf_line | output | 26 | Line address (byte address bits [31:6]) of the offered request |
| pf_ready | input | 1 | The consumer takes the offered request |

## Verification
On every cycle the assertions check four things: the output holds while it is stalled, the queue never exceeds its depth, no two waiting requests name the same line, and each stream table keeps exactly one most-recently-used entry so that its age order stays a permutation. They also check that a stride request only comes from an entry that already held confidence. Only the bench scenarios can show the pattern behaviour. These include the replacement depth of each table measured by how many allocations a stream survives, the exact line chosen in each direction, the suppression of requests at a 2 KB window edge, and the dropping of duplicates and of requests that find the queue full.

// File: rtl/pf_pkg.sv
package pf_pkg;
    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_UP     = 2'd1,
        SRC_DOWN   = 2'd2,
        SRC_STRIDE = 2'd3
    } pf_src_e;
endpackage

// File: rtl/pf_stream_table.sv
module pf_stream_table #(
    parameter int ENTRIES = 16,
    parameter int LINE_W  = 26,
    parameter bit DESCEND = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [LINE_W-1:0] ld_line,
    input  logic              alloc,
    output logic              hit,
    output logic              advance
);
    localparam int AGE_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic [ENTRIES-1:0]             vld;
        logic [ENTRIES-1:0][LINE_W-1:0] line;
        logic [ENTRIES-1:0][AGE_W-1:0]  age;
    } tbl_t;

    tbl_t tbl_d, tbl_q;
    logic [ENTRIES-1:0] same_m, step_m, zero_age;
    logic [AGE_W-1:0]   touch, victim;
    logic               found, is_step;

    always_comb begin
        tbl_d   = tbl_q;
        found   = 1'b0;
        is_step = 1'b0;
        touch   = '0;
        victim  = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            same_m[i]   = tbl_q.vld[i] && (tbl_q.line[i] == ld_line);
            step_m[i]   = tbl_q.vld[i] && ((DESCEND ? (tbl_q.line[i] - LINE_W'(1))
                                                    : (tbl_q.line[i] + LINE_W'(1))) == ld_line);
            zero_age[i] = (tbl_q.age[i] == '0);
            if (tbl_q.age[i] == AGE_W'(ENTRIES - 1)) begin
                victim = AGE_W'(i);
            end
            if (!found && (same_m[i] || step_m[i])) begin
                found   = 1'b1;
                touch   = AGE_W'(i);
                is_step = step_m[i] && !same_m[i];
            end
        end
        if (!found) begin
            touch = victim;
        end
        hit     = ld_valid && found;
        advance = ld_valid && found && is_step;
        if (ld_valid && (found || alloc)) begin
            tbl_d.vld[touch]  = 1'b1;
            tbl_d.line[touch] = ld_line;
            for (int j = 0; j < ENTRIES; j++) begin
                if (AGE_W'(j) == touch) begin
                    tbl_d.age[j] = '0;
                end else if (tbl_q.age[j] < tbl_q.age[touch]) begin
                    tbl_d.age[j] = tbl_q.age[j] + AGE_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q.vld  <= '0;
            tbl_q.line <= '0;
            for (int j = 0; j < ENTRIES; j++) begin
                tbl_q.age[j] <= AGE_W'(j);
            end
        end else begin
            tbl_q <= tbl_d;
        end
    end

    // R5 / R6: the age order stays a permutation with one most recent entry
    p_single_mru_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(zero_age) == 1);
endmodule

// File: rtl/pf_stride_table.sv
module pf_stride_table #(
    parameter int ENTRIES = 8,
    parameter int ADDR_W  = 32,
    parameter int PC_W    = 32,
    parameter int OFS_W   = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ld_valid,
    input  logic [ADDR_W-1:0]       ld_addr,
    input  logic [PC_W-1:0]         ld_pc,
    output logic                    fire,
    output logic [ADDR_W-OFS_W-1:0] target_line
);
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int TAG_W  = PC_W - IDX_W;
    localparam int LINE_W = ADDR_W - OFS_W;

    typedef struct packed {
        logic [ENTRIES-1:0]             vld;
        logic [ENTRIES-1:0][TAG_W-1:0]  tag;
        logic [ENTRIES-1:0][ADDR_W-1:0] last;
        logic [ENTRIES-1:0][ADDR_W-1:0] stride;
        logic [ENTRIES-1:0][1:0]        conf;
    } str_t;

    str_t str_d, str_q;
    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  tg;
    logic [ADDR_W-1:0] delta;
    logic              hit, repeat_ok;
    logic [1:0]        conf_nx;

    always_comb begin
        str_d       = str_q;
        idx         = ld_pc[IDX_W-1:0];
        tg          = ld_pc[PC_W-1:IDX_W];
        hit         = str_q.vld[idx] && (str_q.tag[idx] == tg);
        delta       = ld_addr - str_q.last[idx];
        repeat_ok   = hit && (delta == str_q.stride[idx]) && (delta != '0);
        conf_nx     = !repeat_ok ? 2'd0 :
                      (str_q.conf[idx] == 2'd3) ? 2'd3 : str_q.conf[idx] + 2'd1;
        fire        = ld_valid && repeat_ok && (conf_nx >= 2'd2);
        target_line = LINE_W'((ld_addr + str_q.stride[idx]) >> OFS_W);
        if (ld_valid) begin
            str_d.vld[idx]    = 1'b1;
            str_d.tag[idx]    = tg;
            str_d.last[idx]   = ld_addr;
            str_d.stride[idx] = hit ? delta : '0;
            str_d.conf[idx]   = hit ? conf_nx : 2'd0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            str_q <= '0;
        end else begin
            str_q <= str_d;
        end
    end

    // R7: a stride request needs confidence built by earlier loads
    p_stride_conf_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (str_q.conf[idx] != 2'd0));
endmodule

// File: rtl/pf_req_fifo.sv
module pf_req_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 26
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_en,
    input  logic [W-1:0] push_line,
    output logic         out_valid,
    output logic [W-1:0] out_line,
    input  logic         out_ready
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        rd;
        logic [PTR_W-1:0]        wr;
        logic [CNT_W-1:0]        cnt;
    } fifo_t;

    fifo_t            f_d, f_q;
    logic [DEPTH-1:0] pend;
    logic             dup, do_push, do_pop;

    always_comb begin
        f_d = f_q;
        dup = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            pend[i] = CNT_W'(PTR_W'(PTR_W'(i) - f_q.rd)) < f_q.cnt;
            if (pend[i] && (f_q.mem[i] == push_line)) begin
                dup = 1'b1;
            end
        end
        out_valid = (f_q.cnt != '0);
        out_line  = f_q.mem[f_q.rd];
        do_push   = push_en && !dup && (f_q.cnt != CNT_W'(DEPTH));
        do_pop    = out_valid && out_ready;
        if (do_push) begin
            f_d.mem[f_q.wr] = push_line;
            f_d.wr          = f_q.wr + PTR_W'(1);
        end
        if (do_pop) begin
            f_d.rd = f_q.rd + PTR_W'(1);
        end
        f_d.cnt = f_q.cnt + CNT_W'(do_push) - CNT_W'(do_pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.cnt <= CNT_W'(DEPTH));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_line)));

    for (genvar a = 0; a < DEPTH; a++) begin : g_da
        for (genvar b = a + 1; b < DEPTH; b++) begin : g_db
            p_distinct_r10: assert property (@(posedge clk) disable iff (!rst_n)
                (pend[a] && pend[b]) |-> (f_q.mem[a] != f_q.mem[b]));
        end
    end
endmodule

// File: rtl/prefetch_tracker.sv
module prefetch_tracker #(
    parameter int ADDR_W       = 32,
    parameter int PC_W         = 32,
    parameter int UP_N         = 16,
    parameter int DOWN_N       = 4,
    parameter int STRIDE_N     = 8,
    parameter int FIFO_DEPTH   = 4,
    parameter int LINE_BYTES   = 64,
    parameter int WINDOW_BYTES = 2048
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           ld_valid,
    input  logic [ADDR_W-1:0]              ld_addr,
    input  logic [PC_W-1:0]                ld_pc,
    output logic                           pf_valid,
    output logic [ADDR_W-$clog2(LINE_BYTES)-1:0] pf_line,
    input  logic                           pf_ready
);
    import pf_pkg::*;

    localparam int OFS_W  = $clog2(LINE_BYTES);
    localparam int LINE_W = ADDR_W - OFS_W;
    localparam int WIN_W  = $clog2(WINDOW_BYTES) - OFS_W;

    logic [LINE_W-1:0] ld_line, cand_line, stride_line;
    logic              up_hit, up_adv, down_hit, down_adv, stride_fire;
    logic              alloc, in_window, push;
    pf_src_e           src;

    assign ld_line = ld_addr[ADDR_W-1:OFS_W];
    assign alloc   = !up_hit && !down_hit;

    pf_stream_table #(.ENTRIES(UP_N), .LINE_W(LINE_W), .DESCEND(1'b0)) u_up (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_line(ld_line),
        .alloc(alloc), .hit(up_hit), .advance(up_adv));

    pf_stream_table #(.ENTRIES(DOWN_N), .LINE_W(LINE_W), .DESCEND(1'b1)) u_down (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_line(ld_line),
        .alloc(alloc), .hit(down_hit), .advance(down_adv));

    pf_stride_table #(.ENTRIES(STRIDE_N), .ADDR_W(ADDR_W), .PC_W(PC_W), .OFS_W(OFS_W)) u_stride (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr),
        .ld_pc(ld_pc), .fire(stride_fire), .target_line(stride_line));

    always_comb begin
        src       = SRC_NONE;
        cand_line = ld_line;
        if (up_adv) begin
            src       = SRC_UP;
            cand_line = ld_line + LINE_W'(1);
        end else if (down_adv) begin
            src       = SRC_DOWN;
            cand_line = ld_line - LINE_W'(1);
        end else if (stride_fire && (stride_line != ld_line)) begin
            src       = SRC_STRIDE;
            cand_line = stride_line;
        end
        in_window = (cand_line[LINE_W-1:WIN_W] == ld_line[LINE_W-1:WIN_W]);
        push      = ld_valid && (src != SRC_NONE) && in_window;
    end

    pf_req_fifo #(.DEPTH(FIFO_DEPTH), .W(LINE_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push_en(push), .push_line(cand_line),
        .out_valid(pf_valid), .out_line(pf_line), .out_ready(pf_ready));
endmodule

// File: tb/prefetch_tracker_test.sv
module prefetch_tracker_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_valid = 1'b0;
    logic [31:0] ld_addr = '0;
    logic [31:0] ld_pc = '0;
    logic        pf_valid;
    logic [25:0] pf_line;
    logic        pf_ready = 1'b1;

    int    errors = 0;
    int    checks = 0;
    int    cycles = 0;
    int    upc = 32'h100;
    string cur_req = "R1";
    logic [25:0] exp_q[$];
    string       req_q[$];

    prefetch_tracker uut (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr),
        .ld_pc(ld_pc), .pf_valid(pf_valid), .pf_line(pf_line), .pf_ready(pf_ready));

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++; checks++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected < 100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // monitor: compares each accepted request with the scoreboard
    always @(negedge clk) begin
        if (rst_n && pf_valid && pf_ready) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL %s: unexpected prefetch actual=%h expected none", cur_req, pf_line);
            end else begin
                logic [25:0] e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                if (e != pf_line) begin
                    errors++;
                    $display("FAIL %s: prefetch line actual=%h expected=%h", r, pf_line, e);
                end
            end
        end
    end

    task automatic expect_line(input logic [25:0] l, input string r);
        exp_q.push_back(l);
        req_q.push_back(r);
    endtask

    task automatic load(input logic [31:0] a, input logic [31:0] pc);
        @(negedge clk);
        ld_valid = 1'b1;
        ld_addr  = a;
        ld_pc    = pc;
        @(posedge clk);
        #1 ld_valid = 1'b0;
    endtask

    task automatic sload(input logic [25:0] l);
        upc++;
        load({l, 6'b0}, upc);
    endtask

    task automatic do_reset(input string r);
        @(negedge clk);
        rst_n    = 1'b0;
        pf_ready = 1'b1;
        exp_q.delete();
        req_q.delete();
        repeat (2) @(negedge clk);
        rst_n   = 1'b1;
        cur_req = r;
    endtask

    task automatic settle(input string r);
        repeat (5) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL %s: missing prefetches actual=0 expected=%0d more", r, exp_q.size());
        end
    endtask

    task automatic check_bit(input logic act, input logic exp, input string r);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: pf_valid actual=%b expected=%b", r, act, exp);
        end
    endtask

    task automatic check_line(input logic [25:0] act, input logic [25:0] exp, input string r);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: pf_line actual=%h expected=%h", r, act, exp);
        end
    endtask

    initial begin
        // R1: reset state
        do_reset("R1");
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check_bit(pf_valid, 1'b0, "R1");
        end

        // R2: same-line loads only refresh
        do_reset("R2");
        sload(26'h1510); sload(26'h1510); sload(26'h1510);
        expect_line(26'h1512, "R2");
        sload(26'h1511);
        settle("R2");

        // R3: upward stream
        do_reset("R3");
        sload(26'h1010);
        expect_line(26'h1012, "R3"); sload(26'h1011);
        expect_line(26'h1013, "R3"); sload(26'h1012);
        expect_line(26'h1014, "R3"); sload(26'h1013);
        settle("R3");

        // R4: downward stream
        do_reset("R4");
        sload(26'h1218);
        expect_line(26'h1216, "R4"); sload(26'h1217);
        expect_line(26'h1215, "R4"); sload(26'h1216);
        settle("R4");

        // R5: upward table survives 15 newer streams
        do_reset("R5");
        sload(26'h2010);
        for (int k = 0; k < 15; k++) sload(26'hA000 + 26'(4 * k));
        expect_line(26'h2012, "R5");
        sload(26'h2011);
        settle("R5");
        // R5: lost after 16
        do_reset("R5");
        sload(26'h2010);
        for (int k = 0; k < 16; k++) sload(26'hA000 + 26'(4 * k));
        sload(26'h2011);
        settle("R5");
        // R5: a refresh counts as use
        do_reset("R5");
        sload(26'h2010);
        for (int k = 0; k < 15; k++) sload(26'hA000 + 26'(4 * k));
        sload(26'h2010);
        sload(26'hB000);
        expect_line(26'h2012, "R5");
        sload(26'h2011);
        settle("R5");

        // R6: downward table depth 4
        do_reset("R6");
        sload(26'h4010);
        for (int k = 0; k < 3; k++) sload(26'hC000 + 26'(4 * k));
        expect_line(26'h400E, "R6");
        sload(26'h400F);
        settle("R6");
        do_reset("R6");
        sload(26'h4010);
        for (int k = 0; k < 4; k++) sload(26'hC000 + 26'(4 * k));
        sload(26'h400F);
        settle("R6");

        // R7: forward stride 256, then a broken stride
        do_reset("R7");
        load(32'h10000, 32'h40);
        load(32'h10100, 32'h40);
        load(32'h10200, 32'h40);
        expect_line(26'h410, "R7");
        load(32'h10300, 32'h40);
        load(32'h1042C, 32'h40);
        settle("R7");
        // R7: backward stride 192
        do_reset("R7");
        load(32'h20700, 32'h80);
        load(32'h20640, 32'h80);
        load(32'h20580, 32'h80);
        expect_line(26'h810, "R7");
        load(32'h204C0, 32'h80);
        settle("R7");

        // R8: 2 KB window edges
        do_reset("R8");
        sload(26'h901E); sload(26'h901F);
        sload(26'h9041); sload(26'h9040);
        load(32'h30000, 32'hC0);
        load(32'h30200, 32'hC0);
        load(32'h30400, 32'hC0);
        load(32'h30600, 32'hC0);
        settle("R8");

        // R9: order and hold under back-pressure
        do_reset("R9");
        pf_ready = 1'b0;
        sload(26'h5010); sload(26'h5011);
        sload(26'h6010); sload(26'h6011);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check_bit(pf_valid, 1'b1, "R9");
            check_line(pf_line, 26'h5012, "R9");
        end
        expect_line(26'h5012, "R9");
        expect_line(26'h6012, "R9");
        pf_ready = 1'b1;
        settle("R9");

        // R10: duplicate of a waiting request is dropped
        do_reset("R10");
        pf_ready = 1'b0;
        sload(26'h7010); sload(26'h7011);
        sload(26'h7014); sload(26'h7013);
        expect_line(26'h7012, "R10");
        @(negedge clk);
        pf_ready = 1'b1;
        settle("R10");

        // R11: full queue drops a fifth request
        do_reset("R11");
        pf_ready = 1'b0;
        for (int k = 0; k < 5; k++) begin
            sload(26'h8010 + 26'(64 * k));
            sload(26'h8011 + 26'(64 * k));
            if (k < 4) expect_line(26'h8012 + 26'(64 * k), "R11");
        end
        @(negedge clk);
        pf_ready = 1'b1;
        settle("R11");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule